// File: doc/BRIEF.md
# GHASH Galois-Field Multiply-Accumulate Unit

This block carries out one step of the GHASH hash that GCM and GMAC use for authentication. The step is a multiplication in GF(2^128). Three 128-bit operands come in, each as four 32-bit words: the running partial hash Y, a block-cipher output X and the hash subkey H. The block returns the new partial hash. A mode input picks between two operations. In accumulate mode the block folds X into Y first and computes (Y xor X)·H. In plain mode it computes Y·H and does not look at X.

The multiply is bit-serial and handles one multiplier bit per clock. The block reverses the bit order inside every byte of both operands. It then walks the multiplier bits from index 0 upward. For each set bit it XORs the current multiplicand into an accumulator. After each bit it shifts the multiplicand left by one and reduces with the constant 0x87 whenever a bit leaves position 127. When all 128 bits are done, the accumulator is byte-wise bit-reversed once more to give the result. Software or a sequencer loads the operands with a one-cycle start pulse, waits for done, and reads the result. The result stays unchanged until the next computation ends.

Top module: `ghash_mac`

## Requirements
- R1: Each operand and the result are four 32-bit words. Word 0 carries bits 31:0 of the 128-bit value and word 3 carries bits 127:96.
- R2: When `acc_mode_i` is 1, the multiplier is Y xor X. When it is 0, the multiplier is Y alone and the value on `x_i` has no effect on the result.
- R3: The block uses GHASH bit order by reversing the bits inside each byte of the operands and of the result. Byte positions do not move. As a consequence, the value whose only set bit is bit 7 (byte 0 equal to 0x80) is the multiplicative identity.
- R4: The result equals the GHASH field product of the multiplier and H, reduced by x^128 + x^7 + x^2 + x + 1.
- R5: A start pulse seen while `busy_o` is low starts a computation. `busy_o` is high for exactly 128 cycles, starting on the cycle after the start.
- R6: A start pulse seen while `busy_o` is high is ignored. The running computation keeps its operands and its timing.
- R7: `done_o` is high for exactly one cycle. That cycle is the first one after the 128th step, and in it `busy_o` is low and `z_o` holds the new result.
- R8: `z_o` changes only when a computation completes. It holds its value between completions, including the whole time a later computation is running.
- R9: An asynchronous active-low reset makes `busy_o` and `done_o` low and clears `z_o` to zero.
- R10: A zero multiplier gives zero. This covers Y = 0 in plain mode and X = Y in accumulate mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Load the operands and begin a computation when idle |
| acc_mode_i | input | 1 | 1: multiply (Y xor X) by H; 0: multiply Y by H |
| y_i | input | 4x32 | Current partial hash Y, word 0 = bits 31:0 |
| x_i | input | 4x32 | Block-cipher output X, word 0 = bits 31:0 |
| h_i | input | 4x32 | Hash subkey H, word 0 = bits 31:0 |
| busy_o | output | 1 | High while multiplier bits are being processed |
| done_o | output | 1 | One-cycle pulse when `z_o` holds a new result |
| z_o | output | 4x32 | New partial hash, word 0 = bits 31:0 |

## Verification
The bench builds the unit with its default parameters: 32-bit words and the 0x87 reduction constant. With these values a computation lasts the full 128 steps, so the test sequences can reach the reduction at bit 127, the identity value, zero multipliers and start pulses that arrive in the middle of a run. The reference product is computed in the textbook right-shift form on the GCM bit string with the 0xE1 constant. It therefore checks the byte-reversal convention and the reduction as an independent restatement, not as a copy.

// File: rtl/ghash_mac_pkg.sv
package ghash_mac_pkg;

  // Width of one GHASH field element (fixed by the field itself)
  localparam int unsigned GF_BITS  = 128;
  localparam int unsigned BYTE_W   = 8;
  localparam int unsigned GF_BYTES = GF_BITS / BYTE_W;

  typedef logic [GF_BITS-1:0] gf_t;

  typedef enum logic {
    MODE_MUL = 1'b0,   // Y * H
    MODE_ACC = 1'b1    // (Y ^ X) * H
  } mac_mode_e;

  // Multiplication state carried from one step to the next
  typedef struct packed {
    gf_t acc;    // running product
    gf_t mcand;  // multiplicand, scaled by x once per step
  } gf_state_t;

  // Reverse the bit order inside each byte, keep byte positions
  function automatic gf_t brev_bytes(input gf_t v);
    gf_t r;
    for (int b = 0; b < GF_BYTES; b++) begin
      for (int k = 0; k < BYTE_W; k++) begin
        r[BYTE_W*b + k] = v[BYTE_W*b + (BYTE_W-1) - k];
      end
    end
    return r;
  endfunction

  // Multiply the multiplicand by x, folding the overflow back in with poly
  function automatic gf_t gf_times_x(input gf_t v, input logic [BYTE_W-1:0] poly);
    gf_t r;
    r = {v[GF_BITS-2:0], 1'b0};
    if (v[GF_BITS-1]) begin
      r[BYTE_W-1:0] = r[BYTE_W-1:0] ^ poly;
    end
    return r;
  endfunction

  // One bit-serial step: conditional add, then scale the multiplicand
  function automatic gf_state_t gf_step(input gf_state_t st, input logic sel,
                                        input logic [BYTE_W-1:0] poly);
    gf_state_t n;
    n.acc   = sel ? (st.acc ^ st.mcand) : st.acc;
    n.mcand = gf_times_x(st.mcand, poly);
    return n;
  endfunction

endpackage

// File: rtl/ghash_operand_prep.sv
module ghash_operand_prep
  import ghash_mac_pkg::*;
#(
  parameter int unsigned WORD_W    = 32,
  parameter int unsigned NUM_WORDS = GF_BITS / WORD_W
) (
  input  logic                              acc_mode,
  input  logic [NUM_WORDS-1:0][WORD_W-1:0]  y_w,
  input  logic [NUM_WORDS-1:0][WORD_W-1:0]  x_w,
  input  logic [NUM_WORDS-1:0][WORD_W-1:0]  h_w,
  output gf_t                               mplier_rev,
  output gf_t                               mcand_rev
);

  localparam int unsigned BYTES_PER_WORD = WORD_W / BYTE_W;

  gf_t mplier_flat;
  gf_t mcand_flat;

  // Word i sits at bits i*WORD_W upward of the element
  for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
    assign mplier_flat[w*WORD_W +: WORD_W] =
      (mac_mode_e'(acc_mode) == MODE_ACC) ? (y_w[w] ^ x_w[w]) : y_w[w];
    assign mcand_flat[w*WORD_W +: WORD_W] = h_w[w];

    // Reverse each byte of this word in place
    for (genvar b = 0; b < BYTES_PER_WORD; b++) begin : g_byte
      for (genvar k = 0; k < BYTE_W; k++) begin : g_bit
        localparam int unsigned DST = w*WORD_W + b*BYTE_W + k;
        localparam int unsigned SRC = w*WORD_W + b*BYTE_W + (BYTE_W-1) - k;
        assign mplier_rev[DST] = mplier_flat[SRC];
        assign mcand_rev[DST]  = mcand_flat[SRC];
      end
    end
  end

endmodule

// File: rtl/ghash_bit_step.sv
module ghash_bit_step
  import ghash_mac_pkg::*;
#(
  parameter logic [BYTE_W-1:0] REDUCE_POLY = 8'h87
) (
  input  gf_state_t cur,
  input  logic      sel_bit,
  output gf_state_t nxt
);

  always_comb begin
    nxt = gf_step(cur, sel_bit, REDUCE_POLY);
  end

endmodule

// File: rtl/ghash_seq_ctrl.sv
module ghash_seq_ctrl #(
  parameter int unsigned NBITS = 128,
  localparam int unsigned CNT_W = $clog2(NBITS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  output logic             busy,
  output logic             done,
  output logic             load_evt,
  output logic             last_evt,
  output logic [CNT_W-1:0] bit_idx
);

  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(NBITS - 1);

  logic             busy_q;
  logic             done_q;
  logic [CNT_W-1:0] idx_q;

  assign load_evt = start && !busy_q;
  assign last_evt = busy_q && (idx_q == LAST_IDX);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      idx_q  <= '0;
    end else begin
      done_q <= last_evt;
      if (load_evt) begin
        busy_q <= 1'b1;
        idx_q  <= '0;
      end else if (busy_q) begin
        idx_q <= idx_q + 1'b1;
        if (last_evt) begin
          busy_q <= 1'b0;
        end
      end
    end
  end

  assign busy    = busy_q;
  assign done    = done_q;
  assign bit_idx = idx_q;

endmodule

// File: rtl/ghash_mac.sv
module ghash_mac
  import ghash_mac_pkg::*;
#(
  parameter int unsigned       WORD_W      = 32,
  parameter logic [7:0]        REDUCE_POLY = 8'h87,
  localparam int unsigned      NUM_WORDS   = GF_BITS / WORD_W,
  localparam int unsigned      CNT_W       = $clog2(GF_BITS)
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              start_i,
  input  logic                              acc_mode_i,
  input  logic [NUM_WORDS-1:0][WORD_W-1:0]  y_i,
  input  logic [NUM_WORDS-1:0][WORD_W-1:0]  x_i,
  input  logic [NUM_WORDS-1:0][WORD_W-1:0]  h_i,
  output logic                              busy_o,
  output logic                              done_o,
  output logic [NUM_WORDS-1:0][WORD_W-1:0]  z_o
);

  // Named internal events, brought out for the checker
  logic             load_evt;
  logic             last_evt;
  logic [CNT_W-1:0] bit_idx;
  logic             sel_bit;

  gf_t       mplier_rev;
  gf_t       mcand_rev;
  gf_t       mplier_q;
  gf_state_t st_q;
  gf_state_t st_nxt;
  gf_t       res_q;

  ghash_operand_prep #(
    .WORD_W    (WORD_W),
    .NUM_WORDS (NUM_WORDS)
  ) u_prep (
    .acc_mode   (acc_mode_i),
    .y_w        (y_i),
    .x_w        (x_i),
    .h_w        (h_i),
    .mplier_rev (mplier_rev),
    .mcand_rev  (mcand_rev)
  );

  ghash_seq_ctrl #(
    .NBITS (GF_BITS)
  ) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start_i),
    .busy     (busy_o),
    .done     (done_o),
    .load_evt (load_evt),
    .last_evt (last_evt),
    .bit_idx  (bit_idx)
  );

  // Multiplier is shifted right, so the bit under test is always bit 0
  assign sel_bit = mplier_q[0];

  ghash_bit_step #(
    .REDUCE_POLY (REDUCE_POLY)
  ) u_step (
    .cur     (st_q),
    .sel_bit (sel_bit),
    .nxt     (st_nxt)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mplier_q <= '0;
      st_q     <= '0;
      res_q    <= '0;
    end else begin
      if (load_evt) begin
        mplier_q <= mplier_rev;
        st_q     <= '{acc: '0, mcand: mcand_rev};
      end else if (busy_o) begin
        mplier_q <= {1'b0, mplier_q[GF_BITS-1:1]};
        st_q     <= st_nxt;
      end
      if (last_evt) begin
        res_q <= brev_bytes(st_nxt.acc);
      end
    end
  end

  assign z_o = res_q;

endmodule

// File: rtl/ghash_mac_chk.sv
module ghash_mac_chk #(
  parameter int unsigned CNT_W = 7
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start_i,
  input logic             busy_o,
  input logic             done_o,
  input logic             load_evt,
  input logic             last_evt,
  input logic [CNT_W-1:0] bit_idx,
  input logic [127:0]     z_o
);

  // R5
  start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !busy_o) |=> (busy_o && bit_idx == '0));

  // R6
  no_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !last_evt) |=> (busy_o && bit_idx == $past(bit_idx) + 1'b1));

  // R6
  load_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_evt |-> !busy_o);

  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R7
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !busy_o);

  // R7
  busy_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) |-> done_o);

  // R8
  result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !done_o |-> $stable(z_o));

endmodule

bind ghash_mac ghash_mac_chk #(.CNT_W(CNT_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .start_i  (start_i),
  .busy_o   (busy_o),
  .done_o   (done_o),
  .load_evt (load_evt),
  .last_evt (last_evt),
  .bit_idx  (bit_idx),
  .z_o      (z_o)
);

// File: tb/ghash_mac_tb.sv
module ghash_mac_tb;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 100000;

  logic         clk;
  logic         rst_n;
  logic         start_i;
  logic         acc_mode_i;
  logic [127:0] y_v, x_v, h_v;
  logic         busy_o, done_o;
  logic [3:0][31:0] z_o;
  logic [127:0] z_flat;

  int n_cmp;
  int n_bad;

  // model state
  bit           m_busy;
  bit           m_done;
  int           m_left;
  logic [127:0] m_z;
  logic [127:0] m_pend;
  bit           cmp_en;

  ghash_mac u_dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start_i),
    .acc_mode_i (acc_mode_i),
    .y_i        (y_v),
    .x_i        (x_v),
    .h_i        (h_v),
    .busy_o     (busy_o),
    .done_o     (done_o),
    .z_o        (z_o)
  );

  assign z_flat = z_o;

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  // Textbook GCM product on the bit string: bit j of the string is the
  // MSB-first bit j of byte j/8, here held at g[127-j].
  function automatic logic [127:0] to_str(input logic [127:0] v);
    logic [127:0] g;
    for (int j = 0; j < 128; j++) g[127-j] = v[8*(j/8) + 7 - (j%8)];
    return g;
  endfunction

  function automatic logic [127:0] from_str(input logic [127:0] g);
    logic [127:0] v;
    for (int j = 0; j < 128; j++) v[8*(j/8) + 7 - (j%8)] = g[127-j];
    return v;
  endfunction

  function automatic logic [127:0] ref_mac(input bit acc, input logic [127:0] y,
                                           input logic [127:0] x, input logic [127:0] h);
    logic [127:0] s, v, z;
    s = to_str(acc ? (y ^ x) : y);
    v = to_str(h);
    z = '0;
    for (int j = 0; j < 128; j++) begin
      if (s[127-j]) z = z ^ v;
      if (v[0]) v = (v >> 1) ^ {8'hE1, 120'h0};
      else      v = v >> 1;
    end
    return from_str(z);
  endfunction

  task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Cycle model of the handshake
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_busy = 0; m_done = 0; m_left = 0; m_z = '0;
    end else begin
      m_done = 0;
      if (m_busy) begin
        m_left--;
        if (m_left == 0) begin
          m_busy = 0;
          m_done = 1;
          m_z    = m_pend;
        end
      end else if (start_i) begin
        m_busy = 1;
        m_left = 128;
        m_pend = ref_mac(acc_mode_i, y_v, x_v, h_v);
      end
    end
  end

  // Compare on every clock, away from the active edge
  always @(negedge clk) begin
    if (cmp_en) begin
      check("R5/R6 busy", {127'b0, busy_o}, {127'b0, m_busy});
      check("R7 done",    {127'b0, done_o}, {127'b0, m_done});
      check("R8/R4 z",    z_flat, m_z);
    end
  end

  task automatic run_op(input bit acc, input logic [127:0] y, input logic [127:0] x,
                        input logic [127:0] h, output logic [127:0] res);
    @(negedge clk);
    acc_mode_i = acc; y_v = y; x_v = x; h_v = h; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    // extra start pulse mid-run with other operands (R6)
    repeat (40) @(negedge clk);
    y_v = ~y; h_v = ~h; acc_mode_i = ~acc; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    while (!done_o) @(negedge clk);
    res = z_flat;
    @(negedge clk);
  endtask

  initial begin
    logic [127:0] r, r2;
    logic [127:0] hk;
    n_cmp = 0; n_bad = 0; cmp_en = 0;
    rst_n = 1'b0; start_i = 1'b0; acc_mode_i = 1'b0;
    y_v = '0; x_v = '0; h_v = '0;
    #(CLK_PERIOD*2 + 1);
    // R9 reset state
    check("R9 busy", {127'b0, busy_o}, '0);
    check("R9 done", {127'b0, done_o}, '0);
    check("R9 z",    z_flat, '0);
    @(negedge clk);
    rst_n = 1'b1;
    cmp_en = 1;

    hk = 128'h66e94bd4_ef8a2c3b_884cfa59_ca342b2e;

    // R3 identity: byte 0 = 0x80, R2 x ignored in plain mode
    run_op(1'b0, 128'h80, 128'hdeadbeef_0badf00d_12345678_9abcdef0, hk, r);
    check("R3 identity", r, hk);
    // R1 word layout: word 0 of result equals word 0 of H
    check("R1 word0", {96'b0, z_o[0]}, {96'b0, hk[31:0]});
    check("R1 word3", {96'b0, z_o[3]}, {96'b0, hk[127:96]});

    // R10 zero multiplier
    run_op(1'b0, '0, 128'h1234, hk, r);
    check("R10 plain zero", r, '0);
    run_op(1'b1, 128'hfeedface_cafebabe_01020304_a5a55a5a,
                 128'hfeedface_cafebabe_01020304_a5a55a5a, hk, r);
    check("R10 acc x==y", r, '0);

    // R2 plain mode ignores x
    run_op(1'b0, 128'h0123456789abcdef_fedcba9876543210, 128'h0, hk, r);
    run_op(1'b0, 128'h0123456789abcdef_fedcba9876543210, ~128'h0, hk, r2);
    check("R2 x ignored", r2, r);
    // R2 accumulate mode uses y^x
    run_op(1'b1, 128'h0123456789abcdef_0000000000000000,
                 128'h0000000000000000_fedcba9876543210, hk, r2);
    check("R2 acc fold", r2, r);

    // R4 reduction stress: all-ones operands, top bit set in H
    run_op(1'b0, ~128'h0, ~128'h0, ~128'h0, r);
    check("R4 all ones", r, ref_mac(1'b0, ~128'h0, '0, ~128'h0));
    run_op(1'b1, 128'h1, 128'h0, 128'h8000_0000_0000_0000_0000_0000_0000_0001, r);
    check("R4 edge bits", r, ref_mac(1'b1, 128'h1, '0, 128'h8000_0000_0000_0000_0000_0000_0000_0001));

    // R4 pseudo-random patterns, commutativity as extra cross-check
    for (int i = 0; i < 6; i++) begin
      logic [127:0] a, b;
      a = {$urandom, $urandom, $urandom, $urandom};
      b = {$urandom, $urandom, $urandom, $urandom};
      run_op(1'b0, a, '0, b, r);
      run_op(1'b0, b, '0, a, r2);
      check("R4 commute", r2, r);
    end

    // R8 result held while idle
    repeat (5) @(negedge clk);
    check("R8 hold", z_flat, r2);

    cmp_en = 0;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD*WATCHDOG);
    n_bad++;
    n_cmp++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule